// File: doc/BRIEF.md
# I2C Bus Clear Pulse Generator

This block frees an I2C bus that a slave holds with SDA stuck low. While a recovery sequence runs, the block owns SCL and SDA: it toggles SCL a programmed number of times with SDA released. After each SCL high phase it samples SDA. Once SDA reads high, the pulses stop early. An optional stop condition can follow the pulses. Both lines are driven open-drain, so an output enable of 1 pulls the line low.

Software writes a configuration word and a clock divider word into shadow registers. A load request commits them to the active copies. A sequence starts only from a committed enable bit. At completion the block sets a sticky done bit in its interrupt status word and records the final SDA level in a status word. It also clears the enable bit, so a sequence never restarts by itself. The `busy` output tells the normal transfer engine that the block currently owns the bus.

Top module: `i2c_bus_clear`

## Requirements
- R1: A configuration write has no effect on the bus until a load request commits it. `load_busy` is 1 from the cycle after `load_req` until the commit, which takes one further cycle.
- R2: The pulse count sits in configuration bits [23:16]. When SDA stays low, exactly that many SCL low/high pulses are driven. A count of 0 drives no pulses.
- R3: SDA is sampled at the end of every SCL high phase. A high sample ends the pulse train after the current pulse.
- R4: With configuration bit 1 set, the pulses are followed by a stop condition. Its order is: SCL low with SDA pulled low, then SCL released, then SDA released. This adds exactly one SCL rising edge, and `sda_oe` rises only while `scl_oe` is 1 and falls only while it is 0.
- R5: Every SCL low and every SCL high phase lasts divisor+1 clock cycles. The divisor is divider-word bits [31:16] when `hs_mode` is 0 and bits [15:0] when it is 1.
- R6: At completion, bit 11 of `int_status` becomes 1 and stays 1 until an interrupt write with bit 11 set clears it. Interrupt writes with bit 11 clear leave it unchanged.
- R7: Bit 0 of `status_rdata` holds the SDA level sampled in the final cycle of the sequence.
- R8: Configuration bit 0 (enable) reads back 0 once the sequence completes.
- R9: `scl_oe` and `sda_oe` are 0 whenever `busy` is 0. `busy` is 1 from the start of the sequence through its final cycle.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the shadow configuration word |
| cfg_wdata | input | 32 | Configuration word: bit 0 enable, bit 1 stop, [23:16] pulse count |
| div_wr | input | 1 | Write strobe for the shadow divider word |
| div_wdata | input | 32 | Divider word: [31:16] standard divisor, [15:0] high-speed divisor |
| load_req | input | 1 | Request to commit the shadow words |
| load_busy | output | 1 | Commit pending |
| hs_mode | input | 1 | Selects the high-speed divisor |
| int_wr | input | 1 | Interrupt status write strobe (write 1 to clear) |
| int_wdata | input | 32 | Interrupt status write data |
| int_status | output | 32 | Interrupt status; bit 11 is done |
| cfg_rdata | output | 32 | Shadow configuration readback |
| status_rdata | output | 32 | Bit 0: SDA was high at the end |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| busy | output | 1 | Sequence owns the bus |

## Verification
The assertions check on every cycle that the lines are released outside a sequence and that the stop edges keep their order against SCL. They also check that the done bit is sticky and is set, with the enable bit cleared, in the cycle after `busy` falls. The bench's scenarios cover the rest, using a model slave that holds SDA low for a set number of SCL rising edges. From this model they show the number of pulses driven, the early exit on a high SDA sample, and the final SDA status. The scenarios also cover the phase lengths under both divisors and the fact that an uncommitted enable has no effect.

// File: rtl/bus_clr_pkg.sv
// Shared constants and the sequencer state type for the bus clear block.
package bus_clr_pkg;
    localparam int REG_W    = 32;
    localparam int DIV_W    = 16;
    localparam int CNT_W    = 8;
    localparam int EN_BIT   = 0;
    localparam int STOP_BIT = 1;
    localparam int CNT_LSB  = 16;
    localparam int DONE_BIT = 11;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOW, ST_HIGH, ST_STP_A, ST_STP_B, ST_STP_C, ST_FIN
    } seq_state_t;
endpackage

// File: rtl/bus_clr_regs.sv
// Shadow and active configuration registers with the load handshake,
// plus the sticky done interrupt bit. Assumes fin is a one-cycle pulse.
module bus_clr_regs
    import bus_clr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             div_wr,
    input  logic [REG_W-1:0] div_wdata,
    input  logic             load_req,
    input  logic             int_wr,
    input  logic [REG_W-1:0] int_wdata,
    input  logic             fin,
    output logic [REG_W-1:0] cfg_shadow,
    output logic             act_en,
    output logic             act_stop,
    output logic [CNT_W-1:0] act_cnt,
    output logic [DIV_W-1:0] act_std,
    output logic [DIV_W-1:0] act_hs,
    output logic             load_busy,
    output logic             irq_done
);
    logic [REG_W-1:0] div_shadow;
    logic [REG_W-1:0] cfg_act;
    logic [REG_W-1:0] div_act;

    // Shadow words: software writes, enable cleared at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_shadow <= '0;
            div_shadow <= '0;
        end else begin
            if (cfg_wr) cfg_shadow <= cfg_wdata;
            else if (fin) cfg_shadow[EN_BIT] <= 1'b0;
            if (div_wr) div_shadow <= div_wdata;
        end
    end

    // Load handshake: request marks pending, next cycle commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_busy <= 1'b0;
            cfg_act   <= '0;
            div_act   <= '0;
        end else begin
            if (load_busy) begin
                load_busy <= 1'b0;
                cfg_act   <= cfg_shadow;
                div_act   <= div_shadow;
            end else begin
                if (load_req) load_busy <= 1'b1;
                if (fin) cfg_act[EN_BIT] <= 1'b0;
            end
        end
    end

    // Sticky done flag, cleared by writing 1 to its bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                               irq_done <= 1'b0;
        else if (fin)                             irq_done <= 1'b1;
        else if (int_wr && int_wdata[DONE_BIT])   irq_done <= 1'b0;
    end

    assign act_en   = cfg_act[EN_BIT];
    assign act_stop = cfg_act[STOP_BIT];
    assign act_cnt  = cfg_act[CNT_LSB +: CNT_W];
    assign act_std  = div_act[REG_W-1 -: DIV_W];
    assign act_hs   = div_act[DIV_W-1:0];
endmodule

// File: rtl/bus_clr_div.sv
// Phase timer: raises tick after lim+1 cycles of run, then restarts.
// Assumes run drops between sequences so each phase starts at zero.
module bus_clr_div
    import bus_clr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hs,
    input  logic [DIV_W-1:0] std_lim,
    input  logic [DIV_W-1:0] hs_lim,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // Divisor selection by speed mode.
    always_comb lim = hs ? hs_lim : std_lim;

    assign tick = run && (cnt == lim);

    // Phase counter, cleared on tick or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bus_clr_seq.sv
// Pulse and stop sequencer. Drives open-drain enables, samples SDA at the
// end of each high phase, reports completion with a one-cycle fin pulse.
module bus_clr_seq
    import bus_clr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop_en,
    input  logic [CNT_W-1:0] pulse_cnt,
    input  logic             tick,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             fin,
    output logic             sda_ok
);
    seq_state_t       state;
    logic [CNT_W-1:0] done_cnt;
    logic [CNT_W-1:0] next_cnt;

    assign next_cnt = done_cnt + 1'b1;

    // State and pulse counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            done_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    done_cnt <= '0;
                    if (pulse_cnt != '0) state <= ST_LOW;
                    else if (stop_en)    state <= ST_STP_A;
                    else                 state <= ST_FIN;
                end
                ST_LOW:  if (tick) state <= ST_HIGH;
                ST_HIGH: if (tick) begin
                    done_cnt <= next_cnt;
                    if (sda_in || next_cnt == pulse_cnt)
                        state <= stop_en ? ST_STP_A : ST_FIN;
                    else
                        state <= ST_LOW;
                end
                ST_STP_A: if (tick) state <= ST_STP_B;
                ST_STP_B: if (tick) state <= ST_STP_C;
                ST_STP_C: if (tick) state <= ST_FIN;
                ST_FIN:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Final SDA level captured in the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)              sda_ok <= 1'b0;
        else if (state == ST_FIN) sda_ok <= sda_in;
    end

    // Line drive decoded from the state.
    always_comb begin
        scl_oe = (state == ST_LOW) || (state == ST_STP_A);
        sda_oe = (state == ST_STP_A) || (state == ST_STP_B);
    end

    assign busy = (state != ST_IDLE);
    assign fin  = (state == ST_FIN);
endmodule

// File: rtl/i2c_bus_clear.sv
// Top of the bus clear generator: registers, phase timer and sequencer.
// Assumes sda_in is already synchronised to clk.
module i2c_bus_clear
    import bus_clr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic        div_wr,
    input  logic [31:0] div_wdata,
    input  logic        load_req,
    output logic        load_busy,
    input  logic        hs_mode,
    input  logic        int_wr,
    input  logic [31:0] int_wdata,
    output logic [31:0] int_status,
    output logic [31:0] cfg_rdata,
    output logic [31:0] status_rdata,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        busy
);
    logic             act_en;
    logic             act_stop;
    logic [CNT_W-1:0] act_cnt;
    logic [DIV_W-1:0] act_std;
    logic [DIV_W-1:0] act_hs;
    logic             irq_done;
    logic             tick;
    logic             fin;
    logic             sda_ok;
    logic             start;

    assign start = act_en && !busy;

    bus_clr_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .load_req(load_req), .int_wr(int_wr), .int_wdata(int_wdata),
        .fin(fin), .cfg_shadow(cfg_rdata),
        .act_en(act_en), .act_stop(act_stop), .act_cnt(act_cnt),
        .act_std(act_std), .act_hs(act_hs),
        .load_busy(load_busy), .irq_done(irq_done)
    );

    bus_clr_div u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .hs(hs_mode),
        .std_lim(act_std), .hs_lim(act_hs), .tick(tick)
    );

    bus_clr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .stop_en(act_stop),
        .pulse_cnt(act_cnt), .tick(tick), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
        .fin(fin), .sda_ok(sda_ok)
    );

    // Status words assembled from the flags.
    always_comb begin
        int_status           = '0;
        int_status[DONE_BIT] = irq_done;
        status_rdata         = {31'b0, sda_ok};
    end
endmodule

// File: rtl/bus_clr_chk.sv
// Protocol checker for i2c_bus_clear, attached by bind.
module bus_clr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        scl_oe,
    input logic        sda_oe,
    input logic        int_wr,
    input logic [31:0] int_wdata,
    input logic [31:0] int_status,
    input logic [31:0] cfg_rdata
);
    assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    assert_stop_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> scl_oe);

    assert_stop_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_oe);

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[11] && !(int_wr && int_wdata[11])) |=> int_status[11]);

    assert_done_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> int_status[11]);

    assert_en_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !cfg_rdata[0]);
endmodule

bind i2c_bus_clear bus_clr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .int_wr(int_wr), .int_wdata(int_wdata), .int_status(int_status),
    .cfg_rdata(cfg_rdata)
);

// File: tb/i2c_bus_clear_tb.sv
module i2c_bus_clear_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        div_wr = 1'b0;
    logic [31:0] div_wdata = '0;
    logic        load_req = 1'b0;
    logic        load_busy;
    logic        hs_mode = 1'b0;
    logic        int_wr = 1'b0;
    logic [31:0] int_wdata = '0;
    logic [31:0] int_status;
    logic [31:0] cfg_rdata;
    logic [31:0] status_rdata;
    logic        sda_in;
    logic        scl_oe;
    logic        sda_oe;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rises = 0;
    int dev_base = 0;
    int dev_k = 0;
    int hi_run = 0;
    int lo_run = 0;
    int last_hi = 0;
    int last_lo = 0;
    logic scl_prev = 1'b1;
    logic scl_line;

    always #2 clk = ~clk;

    i2c_bus_clear u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata), .load_req(load_req),
        .load_busy(load_busy), .hs_mode(hs_mode), .int_wr(int_wr),
        .int_wdata(int_wdata), .int_status(int_status), .cfg_rdata(cfg_rdata),
        .status_rdata(status_rdata), .sda_in(sda_in), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .busy(busy)
    );

    // Bus model: slave holds SDA low until it has seen dev_k SCL rising edges.
    assign scl_line = !scl_oe;
    assign sda_in   = !sda_oe && !((rises - dev_base) < dev_k);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        scl_prev <= scl_line;
        if (scl_line && !scl_prev) begin
            rises   <= rises + 1;
            last_lo <= lo_run;
        end
        if (!scl_line && scl_prev) last_hi <= hi_run;
        hi_run <= scl_line ? hi_run + 1 : 0;
        lo_run <= scl_line ? 0 : lo_run + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic wr_div(input logic [31:0] d);
        @(negedge clk); div_wr = 1'b1; div_wdata = d;
        @(negedge clk); div_wr = 1'b0;
    endtask

    task automatic wr_int(input logic [31:0] d);
        @(negedge clk); int_wr = 1'b1; int_wdata = d;
        @(negedge clk); int_wr = 1'b0;
    endtask

    task automatic do_load();
        @(negedge clk); load_req = 1'b1;
        @(negedge clk); load_req = 1'b0;
        chk(load_busy == 1'b1, "R1 load pending", int'(load_busy), 1);
        @(negedge clk);
        chk(load_busy == 1'b0, "R1 load committed", int'(load_busy), 0);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (int_status[11]) break;
        end
    endtask

    // {count[7:0], slave_hold_edges[7:0], stop}
    localparam logic [16:0] VEC [8] = '{
        {8'd9, 8'd3,  1'b0}, {8'd9, 8'd3,  1'b1},
        {8'd4, 8'd10, 1'b0}, {8'd4, 8'd10, 1'b1},
        {8'd4, 8'd5,  1'b1}, {8'd0, 8'd0,  1'b0},
        {8'd1, 8'd0,  1'b1}, {8'd9, 8'd12, 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(scl_oe == 0 && sda_oe == 0, "R10 lines", int'(scl_oe), 0);
        chk(busy == 0 && load_busy == 0, "R10 busy", int'(busy), 0);
        chk(int_status == 0 && status_rdata == 0, "R10 status", int'(int_status), 0);
        rst_n = 1'b1;
        wr_div({16'd3, 16'd1});

        // R1: written but not committed enable does nothing
        dev_base = rises; dev_k = 0;
        wr_cfg({8'd0, 8'd9, 14'd0, 2'b01});
        repeat (40) @(negedge clk);
        chk(busy == 0 && rises == dev_base, "R1 no start before load", rises - dev_base, 0);

        for (int v = 0; v < 8; v++) begin
            int cnt, k, term, exp_r, exp_s, got_r;
            cnt  = int'(VEC[v][16:9]);
            k    = int'(VEC[v][8:1]);
            term = int'(VEC[v][0]);
            exp_r = (cnt == 0) ? 0 : ((k < 1 ? 1 : k) < cnt ? (k < 1 ? 1 : k) : cnt);
            exp_r = exp_r + term;
            exp_s = (k <= cnt + term) ? 1 : 0;
            @(negedge clk);
            dev_base = rises; dev_k = k;
            wr_cfg({8'd0, cnt[7:0], 14'd0, term[0], 1'b1});
            do_load();
            wait_done();
            @(negedge clk);
            got_r = rises - dev_base;
            chk(got_r == exp_r, "R2/R3/R4 pulse count", got_r, exp_r);
            chk(status_rdata[0] == exp_s[0], "R7 final sda", int'(status_rdata[0]), exp_s);
            chk(int_status[11] == 1'b1, "R6 done set", int'(int_status[11]), 1);
            chk(cfg_rdata[0] == 1'b0, "R8 enable cleared", int'(cfg_rdata[0]), 0);
            chk(busy == 0 && scl_oe == 0 && sda_oe == 0, "R9 released", int'(busy), 0);
            wr_int(32'h0000_0800);
            chk(int_status[11] == 1'b0, "R6 cleared by write", int'(int_status[11]), 0);
        end

        // R6: sticky, writes without bit 11 ignored
        dev_base = rises; dev_k = 1;
        wr_cfg({8'd0, 8'd2, 14'd0, 2'b01});
        do_load();
        wait_done();
        repeat (20) @(negedge clk);
        wr_int(32'hFFFF_F7FF);
        chk(int_status[11] == 1'b1, "R6 sticky", int'(int_status[11]), 1);
        wr_int(32'h0000_0800);
        chk(int_status[11] == 1'b0, "R6 clear", int'(int_status[11]), 0);

        // R5: phase lengths, standard divisor 3 -> 4 cycles
        hs_mode = 1'b0;
        dev_base = rises; dev_k = 50;
        wr_cfg({8'd0, 8'd2, 14'd0, 2'b01});
        do_load();
        wait_done();
        chk(last_hi == 4, "R5 std high phase", last_hi, 4);
        chk(last_lo == 4, "R5 std low phase", last_lo, 4);
        wr_int(32'h0000_0800);

        // R5: high-speed divisor 1 -> 2 cycles
        hs_mode = 1'b1;
        dev_base = rises; dev_k = 50;
        wr_cfg({8'd0, 8'd2, 14'd0, 2'b01});
        do_load();
        wait_done();
        chk(last_hi == 2, "R5 hs high phase", last_hi, 2);
        chk(last_lo == 2, "R5 hs low phase", last_lo, 2);
        chk((rises - dev_base) == 2, "R2 count with hs", rises - dev_base, 2);

        // R10: reset again clears flags
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(int_status == 0 && status_rdata == 0 && cfg_rdata == 0, "R10 reset again",
            int'(int_status[11]), 0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule